// File: doc/BRIEF.md
# Sampling-Ring Stop and Region-of-Interest Readout Controller

This block is the digital sequencer for a switched-capacitor waveform sampler. The analog cells of each channel form a ring. A travelling write pulse fills the ring one cell at a time and keeps going until it is halted. Here the write pulse is modelled as a cell-index counter that moves forward on a sample strobe. Asserting `arm` while the block is idle captures the configuration, resets the write index and starts writing. The next cell ahead of the write index is always reported as the cell to clear, so that charge left from the previous turn is removed before that cell is written again.

A trigger accepted while writing starts a programmable delay. When the delay expires, writing halts and the current write index is latched as the stop cell. The block then reads out only a window of cells that starts at the stop cell and wraps around the ring. It produces one physical cell address per readout pace strobe, together with the channel address that a multiplexer or a parallel readout path needs. Channel segments can be joined into rings of 1, 2, 4 or 8 segments. The ring length, and so the wrap point, follows the captured mode.

A separate pipeline stage removes the fixed-pattern offset of each digitized sample. It subtracts the offset that belongs to the physical cell and clamps the result to the range of the sample width.

Top module: `ring_roi_ctrl`

## Requirements
- R1: After reset, `busy`, `wr_en` and `rd_valid` are low and `stop_cell`, `wr_cell` and `cor_valid` are zero.
- R2: `arm` while idle sets the write index to 0, and writing is active from the next cycle. While writing, each cycle with `samp_tick` high advances `wr_cell` by one, modulo the ring length `CELLS << casc_mode`. Mode 0 is one segment; modes 1, 2 and 3 join 2, 4 and 8 segments.
- R3: While `wr_en` is high, `clr_cell` equals `wr_cell + 1` modulo the ring length.
- R4: A trigger accepted at clock edge t halts writing at edge t+1+`trig_dly`. At that edge `stop_cell` takes the write index, and it holds that value until the next arm.
- R5: During readout, the k-th cycle with `rd_tick` high (k counted from 0) makes `rd_valid` high one cycle later, with `rd_cell` = (`stop_cell` + k) modulo the ring length. Readout ends after `roi_len` cells, and a `roi_len` of 0 counts as 1.
- R6: `busy` rises with trigger acceptance and falls in the cycle in which the last window cell appears on `rd_valid`. While `busy` is high, `trig` and `arm` are ignored.
- R7: In multiplexed readout (`par_mode` = 0), `rd_chan` equals the captured `ch_sel`, except that its low `casc_mode` bits are replaced by the segment number of the cell (`rd_cell >> log2(CELLS)`).
- R8: In parallel readout (`par_mode` = 1), `rd_chan` carries only the segment number of the cell within the joined ring, and all other bits are zero.
- R9: One cycle after `adc_valid`, `cor_valid` is high and `cor_data` = `adc_data` − `adc_ofs`, with the offset taken as two's complement and the result clamped to 0 … 2^SW−1.
- R10: `casc_mode`, `par_mode`, `ch_sel`, `trig_dly` and `roi_len` are captured at arm. Changing them later has no effect on the current event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start writing and capture configuration (idle only) |
| trig | input | 1 | Trigger request |
| samp_tick | input | 1 | Sample strobe that advances the write index |
| rd_tick | input | 1 | Readout pace strobe |
| casc_mode | input | 2 | Joined segments: 2^mode |
| par_mode | input | 1 | 1 = parallel readout, 0 = multiplexed |
| ch_sel | input | 4 | Channel address for multiplexed readout |
| trig_dly | input | 8 | Stop delay in clock cycles |
| roi_len | input | 14 | Window length in cells |
| adc_valid | input | 1 | Digitized sample present |
| adc_data | input | 12 | Digitized sample, unsigned |
| adc_ofs | input | 12 | Stored offset of the sample's cell, signed |
| wr_en | output | 1 | Writing active |
| wr_cell | output | 13 | Current write index |
| clr_cell | output | 13 | Cell to clear ahead of writing |
| busy | output | 1 | Trigger accepted and window not finished |
| stop_cell | output | 13 | Latched stop index |
| rd_valid | output | 1 | Readout cell address valid |
| rd_cell | output | 13 | Physical cell address of the readout position |
| rd_chan | output | 4 | Channel address for the readout position |
| cor_valid | output | 1 | Corrected sample valid |
| cor_data | output | 12 | Offset-corrected, clamped sample |

## Verification
The stop lands exactly 1+`trig_dly` edges after the trigger edge. Each readout address appears one cycle after its pace strobe, and a corrected sample follows its input after one cycle. A behavioural model in the bench advances on the same clock edge as the design, using the same captured configuration, and every output is compared with it half a period later, so each result is checked in the exact cycle it is due. Directed checks on top of this count the cells produced in each window and probe known clamping cases, each on the cycle after its stimulus.

// File: rtl/ring_roi_pkg.sv
package ring_roi_pkg;
   typedef enum logic [1:0] {
      RR_IDLE  = 2'd0,
      RR_WRITE = 2'd1,
      RR_DELAY = 2'd2,
      RR_READ  = 2'd3
   } rr_state_e;
endpackage

// File: rtl/ring_roi_wptr.sv
module ring_roi_wptr #(
   parameter int IDXW = 13
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            advance,
   input  logic [IDXW-1:0] ring_mask,
   output logic [IDXW-1:0] wr_cell,
   output logic [IDXW-1:0] clr_cell
);
   logic [IDXW-1:0] idx_q;
   logic [IDXW-1:0] idx_inc;

   assign idx_inc = (idx_q + IDXW'(1)) & ring_mask;

   always_ff @(posedge clk) begin
      if (!rst_n)       idx_q <= '0;
      else if (restart) idx_q <= '0;
      else if (advance) idx_q <= idx_inc;
   end

   assign wr_cell  = idx_q;
   assign clr_cell = idx_inc;
endmodule

// File: rtl/ring_roi_seq.sv
module ring_roi_seq
   import ring_roi_pkg::*;
#(
   parameter int LOGC    = 10,
   parameter int SEG_LOG = 3,
   parameter int CHW     = 4,
   parameter int DLYW    = 8,
   parameter int MODEW   = 2,
   localparam int IDXW   = LOGC + SEG_LOG
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            arm,
   input  logic            trig,
   input  logic            rd_tick,
   input  logic [MODEW-1:0] casc_mode,
   input  logic            par_mode,
   input  logic [CHW-1:0]  ch_sel,
   input  logic [DLYW-1:0] trig_dly,
   input  logic [IDXW:0]   roi_len,
   input  logic [IDXW-1:0] wr_cell,
   output logic            restart,
   output logic            writing,
   output logic            busy,
   output logic [IDXW-1:0] ring_mask,
   output logic [IDXW-1:0] stop_cell,
   output logic            rd_valid,
   output logic [IDXW-1:0] rd_cell,
   output logic [CHW-1:0]  rd_chan
);
   rr_state_e        st_q;
   logic [DLYW-1:0]  cnt_q, dly_q;
   logic [IDXW:0]    roi_q, pos_q;
   logic [MODEW-1:0] mode_q;
   logic             par_q;
   logic [CHW-1:0]   sel_q;
   logic [IDXW-1:0]  stop_q;
   logic [IDXW-1:0]  nxt_cell;
   logic [CHW-1:0]   nxt_chan;
   logic             stop_hit, last_pos;

   assign stop_hit = (st_q == RR_DELAY) && (cnt_q == dly_q);
   assign writing  = (st_q == RR_WRITE) || ((st_q == RR_DELAY) && !stop_hit);
   assign restart  = (st_q == RR_IDLE) && arm;
   assign busy     = (st_q == RR_DELAY) || (st_q == RR_READ);
   assign last_pos = (pos_q + 1'b1) >= roi_q;
   assign nxt_cell = (stop_q + pos_q[IDXW-1:0]) & ring_mask;
   assign stop_cell = stop_q;

   // ring length follows the captured joining mode
   assign ring_mask[LOGC-1:0] = '1;
   for (genvar b = 0; b < SEG_LOG; b++) begin : g_mask
      assign ring_mask[LOGC+b] = (b < int'(mode_q));
   end

   // channel address: joined segment bits come from the cell index
   for (genvar b = 0; b < CHW; b++) begin : g_chan
      if (b < SEG_LOG) begin : g_seg
         assign nxt_chan[b] = (b < int'(mode_q)) ? nxt_cell[LOGC+b]
                                                 : (!par_q && sel_q[b]);
      end else begin : g_hi
         assign nxt_chan[b] = !par_q && sel_q[b];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= RR_IDLE;
         cnt_q    <= '0;
         dly_q    <= '0;
         roi_q    <= '0;
         pos_q    <= '0;
         mode_q   <= '0;
         par_q    <= 1'b0;
         sel_q    <= '0;
         stop_q   <= '0;
         rd_valid <= 1'b0;
         rd_cell  <= '0;
         rd_chan  <= '0;
      end else begin
         rd_valid <= 1'b0;
         unique case (st_q)
            RR_IDLE: if (arm) begin
               mode_q <= casc_mode;
               par_q  <= par_mode;
               sel_q  <= ch_sel;
               dly_q  <= trig_dly;
               roi_q  <= roi_len;
               st_q   <= RR_WRITE;
            end
            RR_WRITE: if (trig) begin
               cnt_q <= '0;
               st_q  <= RR_DELAY;
            end
            RR_DELAY: begin
               if (stop_hit) begin
                  stop_q <= wr_cell;
                  pos_q  <= '0;
                  st_q   <= RR_READ;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            RR_READ: if (rd_tick) begin
               rd_valid <= 1'b1;
               rd_cell  <= nxt_cell;
               rd_chan  <= nxt_chan;
               pos_q    <= pos_q + 1'b1;
               if (last_pos) st_q <= RR_IDLE;
            end
            default: st_q <= RR_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ring_roi_ofs.sv
module ring_roi_ofs #(
   parameter int SW         = 12,
   parameter bit OFS_SIGNED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adc_valid,
   input  logic [SW-1:0] adc_data,
   input  logic [SW-1:0] adc_ofs,
   output logic          cor_valid,
   output logic [SW-1:0] cor_data
);
   localparam int EW = SW + 2;

   logic signed [EW-1:0] ofs_x, diff;
   logic [SW-1:0]        sat;

   if (OFS_SIGNED) begin : g_sofs
      assign ofs_x = {{2{adc_ofs[SW-1]}}, adc_ofs};
   end else begin : g_uofs
      assign ofs_x = {2'b00, adc_ofs};
   end

   assign diff = $signed({2'b00, adc_data}) - ofs_x;

   always_comb begin
      if (diff[EW-1])                             sat = '0;
      else if (diff > $signed({2'b00, {SW{1'b1}}})) sat = '1;
      else                                        sat = diff[SW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cor_valid <= 1'b0;
         cor_data  <= '0;
      end else begin
         cor_valid <= adc_valid;
         if (adc_valid) cor_data <= sat;
      end
   end
endmodule

// File: rtl/ring_roi_ctrl.sv
module ring_roi_ctrl #(
   parameter int CELLS      = 1024,
   parameter int NCH        = 9,
   parameter int SEG_LOG    = 3,
   parameter int DLYW       = 8,
   parameter int SW         = 12,
   parameter bit OFS_SIGNED = 1'b1,
   localparam int LOGC      = $clog2(CELLS),
   localparam int IDXW      = LOGC + SEG_LOG,
   localparam int CHW       = $clog2(NCH),
   localparam int MODEW     = $clog2(SEG_LOG + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             trig,
   input  logic             samp_tick,
   input  logic             rd_tick,
   input  logic [MODEW-1:0] casc_mode,
   input  logic             par_mode,
   input  logic [CHW-1:0]   ch_sel,
   input  logic [DLYW-1:0]  trig_dly,
   input  logic [IDXW:0]    roi_len,
   input  logic             adc_valid,
   input  logic [SW-1:0]    adc_data,
   input  logic [SW-1:0]    adc_ofs,
   output logic             wr_en,
   output logic [IDXW-1:0]  wr_cell,
   output logic [IDXW-1:0]  clr_cell,
   output logic             busy,
   output logic [IDXW-1:0]  stop_cell,
   output logic             rd_valid,
   output logic [IDXW-1:0]  rd_cell,
   output logic [CHW-1:0]   rd_chan,
   output logic             cor_valid,
   output logic [SW-1:0]    cor_data
);
   if (CELLS < 2 || (CELLS & (CELLS - 1)) != 0) begin : g_bad_cells
      $error("CELLS must be a power of two of at least 2");
   end
   if (CHW < SEG_LOG) begin : g_bad_chw
      $error("channel address narrower than the joined segment count");
   end
   if (NCH < (1 << SEG_LOG)) begin : g_bad_nch
      $error("fewer channels than the deepest joined ring");
   end
   if (SW < 2) begin : g_bad_sw
      $error("sample width too small");
   end

   logic            restart, writing;
   logic [IDXW-1:0] ring_mask;

   ring_roi_seq #(
      .LOGC(LOGC), .SEG_LOG(SEG_LOG), .CHW(CHW), .DLYW(DLYW), .MODEW(MODEW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .rd_tick(rd_tick),
      .casc_mode(casc_mode), .par_mode(par_mode), .ch_sel(ch_sel),
      .trig_dly(trig_dly), .roi_len(roi_len), .wr_cell(wr_cell),
      .restart(restart), .writing(writing), .busy(busy),
      .ring_mask(ring_mask), .stop_cell(stop_cell), .rd_valid(rd_valid),
      .rd_cell(rd_cell), .rd_chan(rd_chan)
   );

   ring_roi_wptr #(.IDXW(IDXW)) u_wptr (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .advance(writing && samp_tick), .ring_mask(ring_mask),
      .wr_cell(wr_cell), .clr_cell(clr_cell)
   );

   ring_roi_ofs #(.SW(SW), .OFS_SIGNED(OFS_SIGNED)) u_ofs (
      .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_data(adc_data),
      .adc_ofs(adc_ofs), .cor_valid(cor_valid), .cor_data(cor_data)
   );

   assign wr_en = writing;
endmodule

// File: rtl/ring_roi_ctrl_chk.sv
module ring_roi_ctrl_chk #(
   parameter int IDXW = 13
) (
   input logic            clk,
   input logic            rst_n,
   input logic            samp_tick,
   input logic            adc_valid,
   input logic            wr_en,
   input logic [IDXW-1:0] wr_cell,
   input logic [IDXW-1:0] clr_cell,
   input logic [IDXW-1:0] ring_mask,
   input logic            busy,
   input logic [IDXW-1:0] stop_cell,
   input logic            rd_valid,
   input logic            cor_valid
);
   assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en) && $past(samp_tick))
         |-> wr_cell == (($past(wr_cell) + IDXW'(1)) & ring_mask));

   assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en) && !$past(samp_tick)) |-> $stable(wr_cell));

   assert_clr_ahead_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((clr_cell - wr_cell) & ring_mask) == IDXW'(1));

   assert_stop_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $stable(stop_cell));

   assert_read_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !wr_en);

   assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> rd_valid);

   assert_cor_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      adc_valid |=> cor_valid);
endmodule

bind ring_roi_ctrl ring_roi_ctrl_chk #(.IDXW(IDXW)) u_chk (
   .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .adc_valid(adc_valid),
   .wr_en(wr_en), .wr_cell(wr_cell), .clr_cell(clr_cell),
   .ring_mask(ring_mask), .busy(busy), .stop_cell(stop_cell),
   .rd_valid(rd_valid), .cor_valid(cor_valid)
);

// File: tb/tb_ring_roi_ctrl.sv
`timescale 1ns/1ps
module tb_ring_roi_ctrl;
   localparam int CELLS = 16;
   localparam int LOGC  = 4;
   localparam int SEGL  = 3;
   localparam int IDXW  = LOGC + SEGL;
   localparam int SW    = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 0, trig = 0, samp_tick = 0, rd_tick = 0, par_mode = 0;
   logic [1:0] casc_mode = 0;
   logic [3:0] ch_sel = 0;
   logic [7:0] trig_dly = 0;
   logic [IDXW:0] roi_len = 0;
   logic adc_valid = 0;
   logic [SW-1:0] adc_data = 0, adc_ofs = 0;
   logic wr_en, busy, rd_valid, cor_valid;
   logic [IDXW-1:0] wr_cell, clr_cell, stop_cell, rd_cell;
   logic [3:0] rd_chan;
   logic [SW-1:0] cor_data;

   always #2.5 clk = ~clk;

   ring_roi_ctrl #(.CELLS(CELLS), .NCH(9), .SEG_LOG(SEGL), .DLYW(8), .SW(SW)) dut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .samp_tick(samp_tick),
      .rd_tick(rd_tick), .casc_mode(casc_mode), .par_mode(par_mode),
      .ch_sel(ch_sel), .trig_dly(trig_dly), .roi_len(roi_len),
      .adc_valid(adc_valid), .adc_data(adc_data), .adc_ofs(adc_ofs),
      .wr_en(wr_en), .wr_cell(wr_cell), .clr_cell(clr_cell), .busy(busy),
      .stop_cell(stop_cell), .rd_valid(rd_valid), .rd_cell(rd_cell),
      .rd_chan(rd_chan), .cor_valid(cor_valid), .cor_data(cor_data)
   );

   int n_chk = 0, n_bad = 0;
   int samp_div = 1, rd_div = 1, cyc = 0;
   bit cmp_on = 0;
   int ev_reads = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // behavioural reference, advanced on every rising edge
   int m_st = 0, m_wp = 0, m_cnt = 0, m_stop = 0, m_k = 0;
   int m_mode = 0, m_dly = 0, m_roi = 0, m_sel = 0, m_par = 0;
   int m_rdv = 0, m_rdc = 0, m_rch = 0, m_cv = 0, m_cd = 0;

   function automatic int ring_len(int mode);
      return CELLS << mode;
   endfunction

   function automatic int m_active();
      return (m_st == 1 || (m_st == 2 && m_cnt != m_dly)) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_wp = 0; m_cnt = 0; m_stop = 0; m_k = 0; m_mode = 0;
         m_dly = 0; m_roi = 0; m_sel = 0; m_par = 0;
         m_rdv = 0; m_rdc = 0; m_rch = 0; m_cv = 0; m_cd = 0;
      end else begin
         automatic int act = m_active();
         automatic int d = int'(adc_data) - int'($signed(adc_ofs));
         m_cv = adc_valid;
         if (adc_valid) m_cd = d < 0 ? 0 : (d > 4095 ? 4095 : d);
         m_rdv = 0;
         if (act && samp_tick) m_wp = (m_wp + 1) % ring_len(m_mode);
         case (m_st)
            0: if (arm) begin
               m_mode = casc_mode; m_par = par_mode; m_sel = ch_sel;
               m_dly = trig_dly; m_roi = roi_len; m_wp = 0; m_st = 1;
            end
            1: if (trig) begin m_cnt = 0; m_st = 2; end
            2: if (m_cnt == m_dly) begin m_stop = m_wp; m_k = 0; m_st = 3; end
               else m_cnt++;
            default: if (rd_tick) begin
               automatic int mask = (1 << m_mode) - 1;
               automatic int seg;
               m_rdv = 1;
               m_rdc = (m_stop + m_k) % ring_len(m_mode);
               seg = m_rdc >> LOGC;
               m_rch = m_par ? (seg & mask) : ((m_sel & ~mask) | (seg & mask));
               m_k++;
               if (m_k >= m_roi) m_st = 0;
            end
         endcase
      end
   end

   // stimulus pacing and per-cycle comparison, away from the rising edge
   always @(negedge clk) begin
      if (cmp_on) begin
         automatic int rl = ring_len(m_mode);
         chk(busy == (m_st >= 2), "R6", "busy", busy, m_st >= 2);
         chk(wr_en == m_active(), "R2", "wr_en", wr_en, m_active());
         chk(int'(wr_cell) == m_wp, "R2", "wr_cell", wr_cell, m_wp);
         if (m_active())
            chk(int'(clr_cell) == (m_wp + 1) % rl, "R3", "clr_cell", clr_cell, (m_wp + 1) % rl);
         chk(int'(stop_cell) == m_stop, "R4", "stop_cell", stop_cell, m_stop);
         chk(rd_valid == m_rdv, "R5", "rd_valid", rd_valid, m_rdv);
         if (m_rdv) begin
            ev_reads++;
            chk(int'(rd_cell) == m_rdc, "R5", "rd_cell", rd_cell, m_rdc);
            chk(int'(rd_chan) == m_rch, m_par ? "R8" : "R7", "rd_chan", rd_chan, m_rch);
         end
         chk(cor_valid == m_cv, "R9", "cor_valid", cor_valid, m_cv);
         if (m_cv) chk(int'(cor_data) == m_cd, "R9", "cor_data", cor_data, m_cd);
      end
      cyc++;
      samp_tick = (cyc % samp_div) == 0;
      rd_tick   = (cyc % rd_div) == 0;
   end

   task automatic run_event(input int mode, input int par, input int sel,
                            input int dly, input int roi, input int pre,
                            input int sdiv, input int rdiv);
      samp_div = sdiv; rd_div = rdiv;
      @(negedge clk);
      arm = 1; casc_mode = 2'(mode); par_mode = par[0]; ch_sel = 4'(sel);
      trig_dly = 8'(dly); roi_len = (IDXW+1)'(roi);
      @(negedge clk);
      arm = 0;
      ev_reads = 0;
      // R10: altered configuration after arm must not matter
      casc_mode = 2'(mode + 1); par_mode = ~par_mode; ch_sel = 4'(sel + 5);
      trig_dly = 8'(dly + 3); roi_len = (IDXW+1)'(roi + 2);
      repeat (pre) @(negedge clk);
      trig = 1;
      @(negedge clk);
      trig = 0;
      repeat (dly + 3) @(negedge clk);
      // R6: trigger and arm while busy are ignored
      trig = 1; arm = 1;
      @(negedge clk);
      trig = 0; arm = 0;
      while (busy) @(negedge clk);
      @(negedge clk);
      chk(ev_reads == (roi == 0 ? 1 : roi), "R10", "window cells", ev_reads, roi == 0 ? 1 : roi);
      chk(!busy && !wr_en, "R6", "idle after window", busy, 0);
   endtask

   task automatic adc_push(input int data, input int ofs, input int exp);
      @(negedge clk);
      adc_valid = 1; adc_data = SW'(data); adc_ofs = SW'(ofs);
      @(negedge clk);
      adc_valid = 0;
      chk(cor_valid && int'(cor_data) == exp, "R9", "clamped sample", cor_data, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk(!busy && !wr_en && !rd_valid, "R1", "flags", {busy, wr_en, rd_valid}, 0);
      chk(stop_cell == 0 && wr_cell == 0 && !cor_valid, "R1", "cells", stop_cell, 0);
      cmp_on = 1;
      run_event(0, 0, 3, 5, 5, 40, 1, 3);     // single segment, wraps several times
      run_event(2, 0, 9, 2, 64, 23, 1, 1);    // four joined, full ring from stop
      run_event(3, 1, 0, 0, 128, 70, 2, 2);   // eight joined, parallel, zero delay
      run_event(1, 0, 6, 7, 0, 11, 3, 4);     // zero window counts as one
      run_event(1, 1, 8, 1, 20, 30, 1, 1);    // two joined, parallel
      adc_push(100, 20, 80);
      adc_push(5, 20, 0);                     // low clamp
      adc_push(4000, 4096 - 200, 4095);       // negative offset, high clamp
      adc_push(4095, 0, 4095);
      adc_push(0, 4095, 1);                   // offset of -1
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule